// File: doc/BRIEF.md
# Scancode Key Injection Sequencer

This block feeds keyboard scancodes into the output byte queue of a keyboard controller. A request carries either one 16-bit key code, or a select that asks for the fixed Ctrl, Alt, Delete sequence. Before any byte moves, the block compares the number of bytes the request needs with the number of free queue slots. If the request fits, the block pushes its bytes into the queue, one per clock cycle. After the last byte of each key it raises a one-cycle keyboard interrupt request.

A key code whose upper byte is zero is sent as its low byte only. Any other code is sent as two bytes, the upper (prefix) byte first and then the low byte. The three-key sequence is accepted only as a whole. It is turned away when the queue cannot hold every one of its bytes, even if some of the keys would fit. While a sequence is running the block reports busy and ignores new requests. A rejected request gives a one-cycle error pulse and leaves the block idle at once.

Top module: `kbd_inject_seq`

## Requirements
- R1: After reset, busy_o, push_o, irq_o and err_o are all low.
- R2: A request accepted at a clock edge with a key code whose upper byte is 0x00 pushes exactly one byte, the low byte, in the next cycle.
- R3: A key code whose upper byte is nonzero pushes two bytes in two consecutive cycles, starting in the cycle after acceptance: the upper byte, then the low byte.
- R4: A two-byte key code with fewer than 2 free slots is rejected: nothing is pushed and busy_o stays low.
- R5: A one-byte key code is rejected when 0 slots are free, and it is accepted when 1 slot is free.
- R6: With combo_i high, the request pushes 0x14, 0x11, 0xE0, 0x71 on four consecutive cycles. key_i is ignored.
- R7: The combined sequence is rejected whole when fewer than 4 slots are free, including exactly 3, and nothing is pushed. It is accepted with exactly 4 free slots.
- R8: With intr_en_i high, irq_o pulses for one cycle in the cycle after each key's final byte. The combined sequence therefore gives three pulses, after its 1st, 2nd and 4th bytes.
- R9: With intr_en_i low, no interrupt pulse is issued, all bytes are still pushed, and err_o stays low.
- R10: busy_o is high from the cycle after acceptance through the cycle of the last push, and low in the cycle that follows. Requests made while busy_o is high cause no push, no error and no later sequence.
- R11: A rejection raises err_o for exactly the one cycle after the request, with busy_o low. A request in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled when busy_o is low |
| combo_i | input | 1 | Select the fixed Ctrl, Alt, Delete sequence instead of key_i |
| key_i | input | 16 | Key code for a single-key request |
| intr_en_i | input | 1 | Keyboard interrupts enabled |
| free_slots_i | input | 5 | Free byte slots in the queue (0 to 16) |
| busy_o | output | 1 | Sequence in progress |
| push_o | output | 1 | Push strobe, one byte into the queue |
| push_data_o | output | 8 | Byte being pushed |
| irq_o | output | 1 | One-cycle keyboard interrupt request |
| err_o | output | 1 | One-cycle pulse: request rejected for lack of space |

## Verification
The bench probes the edges of admission. It sends a two-byte key with 1 and with 2 slots free, a one-byte key with 0 and 1 free, and the sequence with 3 and 4 free. A design that admits on the first key alone would push a partial sequence at 3 free. One with an off-by-one compare would either drop keys that fit or overrun the queue. The bench also counts interrupt pulses against the key boundaries inside the sequence. A design that signals per byte, or only at the end, gives the wrong number of pulses. It sends requests while busy, which a design that re-samples too early would execute twice. Finally it makes a request in the error cycle, which a design that lingers after a rejection would lose.

// File: rtl/kbd_inject_pkg.sv
package kbd_inject_pkg;
  localparam int BYTE_W = 8;
  localparam int KEY_W  = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] kbyte_t;
  typedef logic [KEY_W-1:0]  kcode_t;
endpackage

// File: rtl/kbd_key_split.sv
module kbd_key_split
  import kbd_inject_pkg::*;
(
  input  kcode_t code_i,
  output logic   two_o,
  output kbyte_t first_o,
  output kbyte_t second_o
);
  assign two_o    = |code_i[KEY_W-1:BYTE_W];
  assign first_o  = two_o ? code_i[KEY_W-1:BYTE_W] : code_i[BYTE_W-1:0];
  assign second_o = code_i[BYTE_W-1:0];
endmodule

// File: rtl/kbd_inject_plan.sv
module kbd_inject_plan
  import kbd_inject_pkg::*;
#(
  parameter int NKEYS = 3,
  parameter int MAX_BYTES = 2 * NKEYS,
  parameter int SLOT_W = 5,
  parameter logic [NKEYS-1:0][KEY_W-1:0] COMBO_CODES = '0
) (
  input  logic                              combo_i,
  input  kcode_t                            key_i,
  input  logic [SLOT_W-1:0]                 free_i,
  output logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes_o,
  output logic [MAX_BYTES-1:0]              end_o,
  output logic [SLOT_W-1:0]                 need_o,
  output logic                              fits_o
);
  logic   [NKEYS-1:0] c_two;
  kbyte_t [NKEYS-1:0] c_first, c_second;
  logic   s_two;
  kbyte_t s_first, s_second;

  for (genvar k = 0; k < NKEYS; k++) begin : g_combo
    kbd_key_split u_split (
      .code_i  (COMBO_CODES[k]),
      .two_o   (c_two[k]),
      .first_o (c_first[k]),
      .second_o(c_second[k])
    );
  end

  kbd_key_split u_single (
    .code_i  (key_i),
    .two_o   (s_two),
    .first_o (s_first),
    .second_o(s_second)
  );

  always_comb begin
    int pos;
    bytes_o = '0;
    end_o   = '0;
    pos     = 0;
    if (combo_i) begin
      for (int k = 0; k < NKEYS; k++) begin
        bytes_o[pos] = c_first[k];
        if (c_two[k]) begin
          pos = pos + 1;
          bytes_o[pos] = c_second[k];
        end
        end_o[pos] = 1'b1;
        pos = pos + 1;
      end
    end else begin
      bytes_o[0] = s_first;
      bytes_o[1] = s_second;
      end_o[s_two ? 1 : 0] = 1'b1;
      pos = s_two ? 2 : 1;
    end
    need_o = SLOT_W'(pos);
  end

  // whole request must fit before anything moves
  assign fits_o = free_i >= need_o;
endmodule

// File: rtl/kbd_inject_engine.sv
module kbd_inject_engine
  import kbd_inject_pkg::*;
#(
  parameter int MAX_BYTES = 6,
  parameter int SLOT_W = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_i,
  input  logic                              intr_en_i,
  input  logic [MAX_BYTES-1:0][BYTE_W-1:0]  bytes_i,
  input  logic [MAX_BYTES-1:0]              end_i,
  input  logic [SLOT_W-1:0]                 need_i,
  input  logic                              fits_i,
  output logic                              busy_o,
  output logic                              push_o,
  output kbyte_t                            push_data_o,
  output logic                              irq_o,
  output logic                              err_o
);
  logic [MAX_BYTES-1:0][BYTE_W-1:0] buf_q;
  logic [MAX_BYTES-1:0]             end_q;
  logic [SLOT_W-1:0]                left_q;
  logic                             busy_q, irq_q, err_q;
  logic                             take;

  assign take = req_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      end_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= take && !fits_i;
      irq_q <= busy_q && end_q[0] && intr_en_i;
      if (take && fits_i) begin
        buf_q  <= bytes_i;
        end_q  <= end_i;
        left_q <= need_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        buf_q  <= buf_q >> BYTE_W;
        end_q  <= end_q >> 1;
        left_q <= left_q - 1'b1;
        if (left_q == SLOT_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign push_o      = busy_q;
  assign push_data_o = buf_q[0];
  assign irq_o       = irq_q;
  assign err_o       = err_q;
endmodule

// File: rtl/kbd_inject_seq.sv
module kbd_inject_seq
  import kbd_inject_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NKEYS = 3,
  parameter logic [NKEYS-1:0][KEY_W-1:0] COMBO_CODES = {16'hE071, 16'h0011, 16'h0014},
  localparam int SLOT_W = $clog2(DEPTH + 1),
  localparam int MAX_BYTES = 2 * NKEYS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              combo_i,
  input  logic [15:0]       key_i,
  input  logic              intr_en_i,
  input  logic [SLOT_W-1:0] free_slots_i,
  output logic              busy_o,
  output logic              push_o,
  output logic [7:0]        push_data_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [MAX_BYTES-1:0][BYTE_W-1:0] plan_bytes;
  logic [MAX_BYTES-1:0]             plan_end;
  logic [SLOT_W-1:0]                plan_need;
  logic                             plan_fits;

  kbd_inject_plan #(
    .NKEYS      (NKEYS),
    .MAX_BYTES  (MAX_BYTES),
    .SLOT_W     (SLOT_W),
    .COMBO_CODES(COMBO_CODES)
  ) u_plan (
    .combo_i(combo_i),
    .key_i  (key_i),
    .free_i (free_slots_i),
    .bytes_o(plan_bytes),
    .end_o  (plan_end),
    .need_o (plan_need),
    .fits_o (plan_fits)
  );

  kbd_inject_engine #(
    .MAX_BYTES(MAX_BYTES),
    .SLOT_W   (SLOT_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .intr_en_i  (intr_en_i),
    .bytes_i    (plan_bytes),
    .end_i      (plan_end),
    .need_i     (plan_need),
    .fits_i     (plan_fits),
    .busy_o     (busy_o),
    .push_o     (push_o),
    .push_data_o(push_data_o),
    .irq_o      (irq_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/kbd_inject_seq_chk.sv
module kbd_inject_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic intr_en_i,
  input logic busy_o,
  input logic push_o,
  input logic irq_o,
  input logic err_o
);
  // R4
  err_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !push_o);

  // R11
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  // R2
  req_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> (push_o ^ err_o));

  // R8
  irq_after_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(push_o));

  // R9
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(intr_en_i));

  // R10
  busy_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> !err_o);
endmodule

bind kbd_inject_seq kbd_inject_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .intr_en_i(intr_en_i),
  .busy_o   (busy_o),
  .push_o   (push_o),
  .irq_o    (irq_o),
  .err_o    (err_o)
);

// File: tb/kbd_inject_seq_test.sv
module kbd_inject_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, combo = 1'b0, ien = 1'b1;
  logic [15:0] key = '0;
  logic [4:0]  free = 5'd16;
  logic        busy, push, irq, err;
  logic [7:0]  pdata;

  int n_cmp = 0, n_bad = 0;

  logic       cap_push [1:8];
  logic [7:0] cap_data [1:8];
  logic       cap_irq  [1:8];
  logic       cap_err  [1:8];
  logic       cap_busy [1:8];

  int         exp_n;
  logic       exp_ok;
  logic [7:0] exp_b   [0:5];
  logic       exp_end [0:5];

  always #2 clk = ~clk;

  kbd_inject_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .combo_i(combo), .key_i(key),
    .intr_en_i(ien), .free_slots_i(free), .busy_o(busy), .push_o(push),
    .push_data_o(pdata), .irq_o(irq), .err_o(err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic add_key(input logic [15:0] k);
    if (k[15:8] != 8'h00) begin
      exp_b[exp_n] = k[15:8]; exp_end[exp_n] = 1'b0; exp_n++;
    end
    exp_b[exp_n] = k[7:0]; exp_end[exp_n] = 1'b1; exp_n++;
  endtask

  task automatic model(input logic c, input logic [15:0] k, input int f);
    exp_n = 0;
    for (int i = 0; i < 6; i++) begin exp_b[i] = '0; exp_end[i] = 1'b0; end
    if (c) begin add_key(16'h0014); add_key(16'h0011); add_key(16'hE071); end
    else add_key(k);
    exp_ok = (f >= exp_n);
  endtask

  // request at a negedge, hold req for extra cycles while busy, record 8 cycles
  task automatic capture(input logic c, input logic [15:0] k, input int f,
                         input logic ie, input int extra);
    @(negedge clk);
    combo = c; key = k; free = 5'(f); ien = ie; req = 1'b1;
    @(negedge clk);
    combo = 1'b1; key = 16'h5555; free = 5'd16;
    for (int cy = 1; cy <= 8; cy++) begin
      if (cy > extra) req = 1'b0;
      cap_push[cy] = push; cap_data[cy] = pdata; cap_irq[cy] = irq;
      cap_err[cy] = err; cap_busy[cy] = busy;
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  task automatic verify(input string tag, input logic c, input logic [15:0] k,
                        input int f, input logic ie);
    model(c, k, f);
    for (int cy = 1; cy <= 8; cy++) begin
      logic ep, ei;
      ep = exp_ok && (cy <= exp_n);
      ei = exp_ok && ie && (cy >= 2) && (cy <= exp_n + 1) && exp_end[cy-2];
      check($sformatf("%s R10 cyc%0d push", tag, cy), cap_push[cy], ep);
      check($sformatf("%s R10 cyc%0d busy", tag, cy), cap_busy[cy], ep);
      if (ep) check($sformatf("%s cyc%0d data", tag, cy), cap_data[cy], exp_b[cy-1]);
      check($sformatf("%s R8 cyc%0d irq", tag, cy), cap_irq[cy], ei);
      check($sformatf("%s R11 cyc%0d err", tag, cy), cap_err[cy], !exp_ok && cy == 1);
    end
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0); check("R1 push", push, 0);
    check("R1 irq", irq, 0);   check("R1 err", err, 0);
  endtask

  task automatic t_one_byte;
    capture(1'b0, 16'h001C, 16, 1'b1, 0); verify("R2 one-byte", 1'b0, 16'h001C, 16, 1'b1);
  endtask

  task automatic t_two_byte;
    capture(1'b0, 16'hE075, 2, 1'b1, 0); verify("R3 two-byte free2", 1'b0, 16'hE075, 2, 1'b1);
    capture(1'b0, 16'hE075, 1, 1'b1, 0); verify("R4 two-byte free1", 1'b0, 16'hE075, 1, 1'b1);
  endtask

  task automatic t_one_byte_edge;
    capture(1'b0, 16'h0029, 0, 1'b1, 0); verify("R5 free0", 1'b0, 16'h0029, 0, 1'b1);
    capture(1'b0, 16'h0029, 1, 1'b1, 0); verify("R5 free1", 1'b0, 16'h0029, 1, 1'b1);
  endtask

  task automatic t_combo;
    capture(1'b1, 16'hABCD, 4, 1'b1, 0); verify("R6 combo free4", 1'b1, 16'hABCD, 4, 1'b1);
    capture(1'b1, 16'h0000, 3, 1'b1, 0); verify("R7 combo free3", 1'b1, 16'h0000, 3, 1'b1);
    capture(1'b1, 16'h0000, 16, 1'b1, 0); verify("R8 combo irq", 1'b1, 16'h0000, 16, 1'b1);
  endtask

  task automatic t_irq_off;
    capture(1'b1, 16'h0000, 16, 1'b0, 0); verify("R9 combo ien0", 1'b1, 16'h0000, 16, 1'b0);
    capture(1'b0, 16'hE071, 16, 1'b0, 0); verify("R9 two-byte ien0", 1'b0, 16'hE071, 16, 1'b0);
    ien = 1'b1;
  endtask

  task automatic t_busy_ignore;
    capture(1'b0, 16'hE06B, 16, 1'b1, 2); verify("R10 busy ignore", 1'b0, 16'hE06B, 16, 1'b1);
  endtask

  task automatic t_err_then_accept;
    @(negedge clk);
    combo = 1'b0; key = 16'hE070; free = 5'd1; req = 1'b1;
    @(negedge clk);
    check("R11 err pulse", err, 1);
    check("R11 idle on err", busy, 0);
    key = 16'h0033; free = 5'd16;
    @(negedge clk);
    req = 1'b0;
    check("R11 err one cycle", err, 0);
    check("R11 accepted push", push, 1);
    check("R11 accepted data", pdata, 8'h33);
    @(negedge clk);
    check("R11 done", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1; t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_byte();
    t_two_byte();
    t_one_byte_edge();
    t_combo();
    t_irq_off();
    t_busy_ignore();
    t_err_then_accept();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule